// File: doc/BRIEF.md
# DDR Refresh and Power-State Scheduler

This block keeps one DDR SDRAM rank refreshed and moves it in and out of its low-power states by driving the clock-enable line. A free-running interval counter marks each point at which one auto-refresh falls due. Each due refresh adds to an owed count. While anything is owed, the block asks the command arbiter for the bus. Once it is granted, the block closes every bank with a precharge-all. It then issues the owed refreshes back to back, each spaced by the refresh cycle time, and only then releases the bus.

A host may ask for self refresh (a sleep request) or for power down. The block precharges, drops clock enable together with the entry command, and keeps the rank there until the request is withdrawn. A refresh that falls due during power down wakes the rank, is served, and the rank goes back down. After self-refresh exit, two hold outputs tell the host when commands may follow. Non-read commands are allowed after a short delay and reads after a much longer one. Power-down exit uses a single short delay for both holds. Mode register programming and data transfers are handled elsewhere.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is applied, and for the two clocks that the internal reset synchronizer adds after release, cke is 1, cmd is 0 (no command), and arb_req, busy, rd_hold and nonrd_hold are all 0.
- R2: While the bus is granted, one refresh falls due every REF_INTERVAL clocks. Refresh commands from successive due points are REF_INTERVAL clocks apart, and every refresh owed is eventually issued.
- R3: A refresh sequence starts only after arb_req has been high with arb_gnt high. Its first command is precharge-all (cmd 1), and the next command comes exactly T_RP clocks after it. arb_req stays low while nothing is owed or requested.
- R4: A refresh (cmd 2) is followed by no other command for T_RFC clocks. Refreshes issued back to back are exactly T_RFC clocks apart.
- R5: While the grant is withheld, owed refreshes accumulate up to MAX_POSTPONE and saturate there. When the grant returns, a single precharge-all is followed by exactly the owed number of refreshes.
- R6: On a sleep request the block precharges, then issues self-refresh entry (cmd 3) exactly T_RP clocks later, with cke falling in that same clock.
- R7: When the sleep request is withdrawn, cke rises one clock later. nonrd_hold is high for exactly T_XSNR clocks and rd_hold for exactly T_XSRD clocks, both counted from the first clock with cke high. No command is issued while nonrd_hold is high.
- R8: On a power-down request the block precharges, then issues power-down entry (cmd 4) T_RP clocks later with cke low. When the request is withdrawn, cke rises one clock later and both holds are high for T_PDX clocks.
- R9: A refresh falling due during power down raises cke, waits T_PDX clocks, and runs a precharge-all and the refresh. If the request is still present, the block then re-enters power down.
- R10: Every cke level is held for at least two consecutive clocks. Clock enable is low only in the entry command's clock and during the low-power state, and only entry commands are issued with cke low.
- R11: busy is high whenever a command sequence owns the bus or either hold is high. arb_req stays high from the first command of a sequence until its last wait has ended.
- R12: Self refresh clears the owed count and freezes the interval counter. After exit, the first refresh falls due REF_INTERVAL clocks after the first clock with cke high, and is issued T_RP+1 clocks after that point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| sleep_req | input | 1 | Host asks for self refresh while high |
| pdown_req | input | 1 | Host asks for power down while high |
| arb_gnt | input | 1 | Command arbiter grants the bus to this block |
| arb_req | output | 1 | Bus request to the command arbiter |
| cke | output | 1 | Clock enable to the rank |
| cmd | output | 3 | Command issued this clock: 0 none, 1 precharge-all, 2 refresh, 3 self-refresh entry, 4 power-down entry |
| busy | output | 1 | Sequence in progress or an exit hold is active |
| rd_hold | output | 1 | Host must not issue a read |
| nonrd_hold | output | 1 | Host must not issue any non-read command |

## Verification
The bench builds the block with a refresh interval of 100 clocks, T_RP of 3, T_RFC of 8, exit holds of 12 and 40 clocks, a power-down exit of 1 clock and a backlog limit of 4. The short interval lets several due points pass during one grant outage, so backlog saturation and the back-to-back burst are exercised. It also lets a refresh fall due in the middle of a power-down stay. The exit holds remain short enough that their exact lengths are measured clock by clock. Every command the block issues is compared against the expected code and clock.

// File: rtl/dram_sched_pkg.sv
package dram_sched_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_PREA = 3'd1,
    CMD_REF  = 3'd2,
    CMD_SRE  = 3'd3,
    CMD_PDE  = 3'd4
  } sched_cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PREA,
    ST_WAIT_RP,
    ST_REF,
    ST_WAIT_RFC,
    ST_SRE,
    ST_SELF,
    ST_PDE,
    ST_PDOWN
  } seq_state_e;

endpackage

// File: rtl/refresh_debt_counter.sv
module refresh_debt_counter #(
  parameter int REF_INTERVAL = 1560,
  parameter int MAX_POSTPONE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic freeze,
  input  logic ref_issue,
  output logic owed_any
);

  localparam int IVL_W  = $clog2(REF_INTERVAL);
  localparam int OWED_W = $clog2(MAX_POSTPONE + 1);
  localparam logic [IVL_W-1:0]  IVL_LAST = IVL_W'(REF_INTERVAL - 1);
  localparam logic [OWED_W-1:0] OWED_CAP = OWED_W'(MAX_POSTPONE);

  logic [IVL_W-1:0]  ivl_q, ivl_d;
  logic [OWED_W-1:0] owed_q, owed_d;
  logic              due;

  // interval counter: frozen at zero during self refresh
  always_comb begin
    due   = 1'b0;
    ivl_d = ivl_q + 1'b1;
    if (freeze) begin
      ivl_d = '0;
    end else if (ivl_q == IVL_LAST) begin
      ivl_d = '0;
      due   = 1'b1;
    end
  end

  // owed count: saturating add on due point, subtract on issue
  always_comb begin
    owed_d = owed_q;
    if (freeze) begin
      owed_d = '0;
    end else begin
      if (due && (owed_q != OWED_CAP)) owed_d = owed_d + 1'b1;
      if (ref_issue && (owed_d != '0)) owed_d = owed_d - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_q  <= '0;
      owed_q <= '0;
    end else begin
      ivl_q  <= ivl_d;
      owed_q <= owed_d;
    end
  end

  assign owed_any = (owed_q != '0);

endmodule

// File: rtl/exit_hold_timer.sv
module exit_hold_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         hold
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign hold = (cnt_q != '0);

endmodule

// File: rtl/power_seq_fsm.sv
module power_seq_fsm
  import dram_sched_pkg::*;
#(
  parameter int T_RP  = 4,
  parameter int T_RFC = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic       pdown_req,
  input  logic       arb_gnt,
  input  logic       owed_any,
  input  logic       nonrd_hold,
  output logic       arb_req,
  output logic       cke,
  output sched_cmd_e cmd,
  output logic       seq_active,
  output logic       ref_issue,
  output logic       sr_freeze,
  output logic       exit_sr,
  output logic       exit_pd
);

  localparam int TMAX  = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int TMR_W = $clog2(TMAX + 1);
  localparam logic [TMR_W-1:0] RP_LOAD  = TMR_W'(T_RP - 2);
  localparam logic [TMR_W-1:0] RFC_LOAD = TMR_W'(T_RFC - 2);

  seq_state_e       state_q, state_d, after_wait;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             tmr_en;
  logic             want;

  assign want = owed_any || sleep_req || pdown_req;

  // choice made at the end of every wait: refresh debt first
  always_comb begin
    if (owed_any)       after_wait = ST_REF;
    else if (sleep_req) after_wait = ST_SRE;
    else if (pdown_req) after_wait = ST_PDE;
    else                after_wait = ST_IDLE;
  end

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    tmr_en  = 1'b0;
    exit_sr = 1'b0;
    exit_pd = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (want && !nonrd_hold && arb_gnt) state_d = ST_PREA;
      end
      ST_PREA: begin
        state_d = ST_WAIT_RP;
        tmr_d   = RP_LOAD;
        tmr_en  = 1'b1;
      end
      ST_WAIT_RP: begin
        if (tmr_q == '0) begin
          state_d = after_wait;
        end else begin
          tmr_d  = tmr_q - 1'b1;
          tmr_en = 1'b1;
        end
      end
      ST_REF: begin
        state_d = ST_WAIT_RFC;
        tmr_d   = RFC_LOAD;
        tmr_en  = 1'b1;
      end
      ST_WAIT_RFC: begin
        if (tmr_q == '0) begin
          state_d = after_wait;
        end else begin
          tmr_d  = tmr_q - 1'b1;
          tmr_en = 1'b1;
        end
      end
      ST_SRE: begin
        state_d = ST_SELF;
      end
      ST_SELF: begin
        if (!sleep_req) begin
          state_d = ST_IDLE;
          exit_sr = 1'b1;
        end
      end
      ST_PDE: begin
        state_d = ST_PDOWN;
      end
      ST_PDOWN: begin
        if (!pdown_req || owed_any) begin
          state_d = ST_IDLE;
          exit_pd = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else if (tmr_en) begin
      tmr_q <= tmr_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_PREA: cmd = CMD_PREA;
      ST_REF:  cmd = CMD_REF;
      ST_SRE:  cmd = CMD_SRE;
      ST_PDE:  cmd = CMD_PDE;
      default: cmd = CMD_NOP;
    endcase
  end

  assign cke        = !((state_q == ST_SRE) || (state_q == ST_SELF) ||
                        (state_q == ST_PDE) || (state_q == ST_PDOWN));
  assign seq_active = (state_q != ST_IDLE);
  assign arb_req    = seq_active || (want && !nonrd_hold);
  assign ref_issue  = (state_q == ST_REF);
  assign sr_freeze  = (state_q == ST_SRE) || (state_q == ST_SELF);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_sched_pkg::*;
#(
  parameter int REF_INTERVAL = 1560,
  parameter int MAX_POSTPONE = 8,
  parameter int T_RP         = 4,
  parameter int T_RFC        = 15,
  parameter int T_XSNR       = 12,
  parameter int T_XSRD       = 200,
  parameter int T_PDX        = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic       pdown_req,
  input  logic       arb_gnt,
  output logic       arb_req,
  output logic       cke,
  output logic [2:0] cmd,
  output logic       busy,
  output logic       rd_hold,
  output logic       nonrd_hold
);

  localparam int XMAX = (T_XSRD > T_XSNR) ? ((T_XSRD > T_PDX) ? T_XSRD : T_PDX)
                                          : ((T_XSNR > T_PDX) ? T_XSNR : T_PDX);
  localparam int XW   = $clog2(XMAX + 1);
  localparam logic [XW-1:0] XSNR_V = XW'(T_XSNR);
  localparam logic [XW-1:0] XSRD_V = XW'(T_XSRD);
  localparam logic [XW-1:0] PDX_V  = XW'(T_PDX);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  sched_cmd_e fsm_cmd;
  logic       owed_any, seq_active, ref_issue, sr_freeze;
  logic       exit_sr, exit_pd, hold_load;
  logic [XW-1:0] nonrd_val, rd_val;

  refresh_debt_counter #(
    .REF_INTERVAL (REF_INTERVAL),
    .MAX_POSTPONE (MAX_POSTPONE)
  ) u_debt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .freeze    (sr_freeze),
    .ref_issue (ref_issue),
    .owed_any  (owed_any)
  );

  power_seq_fsm #(
    .T_RP  (T_RP),
    .T_RFC (T_RFC)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .sleep_req  (sleep_req),
    .pdown_req  (pdown_req),
    .arb_gnt    (arb_gnt),
    .owed_any   (owed_any),
    .nonrd_hold (nonrd_hold),
    .arb_req    (arb_req),
    .cke        (cke),
    .cmd        (fsm_cmd),
    .seq_active (seq_active),
    .ref_issue  (ref_issue),
    .sr_freeze  (sr_freeze),
    .exit_sr    (exit_sr),
    .exit_pd    (exit_pd)
  );

  assign hold_load = exit_sr || exit_pd;
  assign nonrd_val = exit_sr ? XSNR_V : PDX_V;
  assign rd_val    = exit_sr ? XSRD_V : PDX_V;

  exit_hold_timer #(.W(XW)) u_nonrd_hold (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (hold_load),
    .load_val (nonrd_val),
    .hold     (nonrd_hold)
  );

  exit_hold_timer #(.W(XW)) u_rd_hold (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (hold_load),
    .load_val (rd_val),
    .hold     (rd_hold)
  );

  assign cmd  = fsm_cmd;
  assign busy = seq_active || nonrd_hold || rd_hold;

endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk
  import dram_sched_pkg::*;
#(
  parameter int T_RP  = 4,
  parameter int T_RFC = 15
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cke,
  input logic [2:0] cmd,
  input logic       arb_req,
  input logic       busy,
  input logic       rd_hold,
  input logic       nonrd_hold
);

  localparam int GW = $clog2(T_RFC + 1);
  localparam int PW = $clog2(T_RP + 1);

  logic [GW-1:0] since_ref;
  logic          ref_seen;
  logic [PW-1:0] since_prea;
  logic          prea_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_ref <= '0;
      ref_seen  <= 1'b0;
    end else if (cmd == CMD_REF) begin
      since_ref <= GW'(1);
      ref_seen  <= 1'b1;
    end else if (since_ref < GW'(T_RFC)) begin
      since_ref <= since_ref + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_prea <= '0;
      prea_valid <= 1'b0;
    end else if (cmd == CMD_PREA) begin
      since_prea <= PW'(1);
      prea_valid <= 1'b1;
    end else begin
      if (since_prea < PW'(T_RP)) since_prea <= since_prea + 1'b1;
      if (!cke) prea_valid <= 1'b0;
    end
  end

  assert_cke_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cke) |=> $stable(cke));

  assert_cke_fall_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (cmd == CMD_SRE || cmd == CMD_PDE));

  assert_low_cke_cmds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (cmd == CMD_NOP || cmd == CMD_SRE || cmd == CMD_PDE));

  assert_ref_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_REF && ref_seen) |-> (since_ref >= GW'(T_RFC)));

  assert_precharged_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_REF || cmd == CMD_SRE || cmd == CMD_PDE) |->
      (prea_valid && since_prea >= PW'(T_RP)));

  assert_quiet_in_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nonrd_hold |-> (cmd == CMD_NOP));

  assert_busy_cover_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (nonrd_hold || rd_hold || cmd != CMD_NOP) |-> busy);

  assert_cmd_owns_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != CMD_NOP) |-> arb_req);

endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
  .T_RP  (T_RP),
  .T_RFC (T_RFC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cke        (cke),
  .cmd        (cmd),
  .arb_req    (arb_req),
  .busy       (busy),
  .rd_hold    (rd_hold),
  .nonrd_hold (nonrd_hold)
);

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb;

  localparam int RI   = 100;
  localparam int MAXP = 4;
  localparam int TRP  = 3;
  localparam int TRFC = 8;
  localparam int XSNR = 12;
  localparam int XSRD = 40;
  localparam int PDX  = 1;
  localparam int SYNC = 2;  // reset synchronizer stages

  logic       clk = 1'b0;
  logic       rst_n, sleep_req, pdown_req, arb_gnt;
  logic       arb_req, cke, busy, rd_hold, nonrd_hold;
  logic [2:0] cmd;

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int    q_code[$];
  int    q_at[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  dram_refresh_sched #(
    .REF_INTERVAL (RI), .MAX_POSTPONE (MAXP), .T_RP (TRP), .T_RFC (TRFC),
    .T_XSNR (XSNR), .T_XSRD (XSRD), .T_PDX (PDX)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .sleep_req (sleep_req), .pdown_req (pdown_req),
    .arb_gnt (arb_gnt), .arb_req (arb_req), .cke (cke), .cmd (cmd),
    .busy (busy), .rd_hold (rd_hold), .nonrd_hold (nonrd_hold)
  );

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic expect_cmd(input int code, input int at, input string tag);
    q_code.push_back(code);
    q_at.push_back(at);
    q_tag.push_back(tag);
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // monitor: every issued command is popped and compared
  always @(negedge clk) begin
    if (rst_n && cmd != 3'd0 && !done) begin
      if (q_code.size() == 0) begin
        check("R2 unexpected command code", int'(cmd), 0);
      end else begin
        automatic int    c = q_code.pop_front();
        automatic int    a = q_at.pop_front();
        automatic string t = q_tag.pop_front();
        check({t, " code"}, int'(cmd), c);
        check({t, " cycle"}, cyc, a);
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sleep_req = 1'b0; pdown_req = 1'b0; arb_gnt = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 cke", int'(cke), 1);
    check("R1 cmd", int'(cmd), 0);
    check("R1 arb_req", int'(arb_req), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 holds", int'(rd_hold) + int'(nonrd_hold), 0);
    rst_n = 1'b1;

    // periodic refresh, due points at k*RI+SYNC
    for (int k = 1; k <= 3; k++) begin
      expect_cmd(1, k*RI + SYNC + 1, "R3 precharge-all");
      expect_cmd(2, k*RI + SYNC + 1 + TRP, "R2 periodic refresh");
    end
    // backlog burst after grant returns at 850
    expect_cmd(1, 851, "R5 burst precharge");
    for (int i = 0; i < MAXP; i++) expect_cmd(2, 851 + TRP + i*TRFC, "R4 R5 burst refresh");
    expect_cmd(1, 9*RI + SYNC + 1, "R5 after burst precharge");
    expect_cmd(2, 9*RI + SYNC + 1 + TRP, "R5 after burst refresh");
    // self refresh
    expect_cmd(1, 951, "R6 sleep precharge");
    expect_cmd(3, 951 + TRP, "R6 self-refresh entry");
    expect_cmd(1, 1101 + RI + 1, "R12 first precharge after exit");
    expect_cmd(2, 1101 + RI + 1 + TRP, "R12 first refresh after exit");
    // power down
    expect_cmd(1, 1251, "R8 pd precharge");
    expect_cmd(4, 1251 + TRP, "R8 pd entry");
    expect_cmd(1, 1302 + PDX + 1, "R9 wake precharge");
    expect_cmd(2, 1302 + PDX + 1 + TRP, "R9 wake refresh");
    expect_cmd(4, 1302 + PDX + 1 + TRP + TRFC, "R9 pd re-entry");
    expect_cmd(1, 1402, "R2 final precharge");
    expect_cmd(2, 1402 + TRP, "R2 final refresh");

    wait_to(1);
    check("R1 cke in sync window", int'(cke), 1);
    wait_to(101);
    check("R3 arb_req idle", int'(arb_req), 0);
    wait_to(102);
    check("R3 arb_req on due", int'(arb_req), 1);
    wait_to(110);
    check("R11 busy in tRFC", int'(busy), 1);
    check("R11 arb_req in tRFC", int'(arb_req), 1);
    wait_to(114);
    check("R11 busy after", int'(busy), 0);
    check("R3 arb_req released", int'(arb_req), 0);

    wait_to(320);
    arb_gnt = 1'b0;
    wait_to(450);
    check("R5 arb_req pending", int'(arb_req), 1);
    check("R5 no cmd without grant", int'(cmd), 0);
    wait_to(850);
    arb_gnt = 1'b1;
    wait_to(866);
    check("R11 arb_req in burst", int'(arb_req), 1);

    wait_to(950);
    sleep_req = 1'b1;
    wait_to(953);
    check("R6 cke before entry", int'(cke), 1);
    wait_to(954);
    check("R6 cke at entry", int'(cke), 0);
    wait_to(1000);
    check("R10 cke low in self refresh", int'(cke), 0);
    wait_to(1100);
    sleep_req = 1'b0;
    check("R7 cke before exit", int'(cke), 0);
    wait_to(1101);
    check("R7 cke after exit", int'(cke), 1);
    check("R7 nonrd_hold start", int'(nonrd_hold), 1);
    check("R7 rd_hold start", int'(rd_hold), 1);
    wait_to(1100 + XSNR);
    check("R7 nonrd_hold last", int'(nonrd_hold), 1);
    wait_to(1101 + XSNR);
    check("R7 nonrd_hold end", int'(nonrd_hold), 0);
    wait_to(1100 + XSRD);
    check("R7 rd_hold last", int'(rd_hold), 1);
    wait_to(1101 + XSRD);
    check("R7 rd_hold end", int'(rd_hold), 0);
    check("R11 busy end", int'(busy), 0);

    wait_to(1250);
    pdown_req = 1'b1;
    wait_to(1254);
    check("R8 cke at pd entry", int'(cke), 0);
    wait_to(1300);
    check("R8 cke in pd", int'(cke), 0);
    wait_to(1302);
    check("R9 cke on wake", int'(cke), 1);
    check("R9 nonrd_hold on wake", int'(nonrd_hold), 1);
    wait_to(1303);
    check("R9 nonrd_hold end", int'(nonrd_hold), 0);
    wait_to(1302 + PDX + 1 + TRP + TRFC);
    check("R9 cke re-entry", int'(cke), 0);
    wait_to(1350);
    pdown_req = 1'b0;
    wait_to(1351);
    check("R8 cke after exit", int'(cke), 1);
    check("R8 nonrd_hold", int'(nonrd_hold), 1);
    check("R8 rd_hold", int'(rd_hold), 1);
    wait_to(1352);
    check("R8 holds end", int'(rd_hold) + int'(nonrd_hold), 0);

    wait_to(1430);
    check("R2 all expected commands seen", q_code.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule